// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes one or more DDR2 ranks from power-up to an operational state without software stepping through each command. A single start pulse latches the configuration (rank count, mode-register base value, extended-mode base value, pad-delay length and calibration enable). The sequencer can first write a default drive setting and wait for impedance calibration. It then inserts a pad delay and walks every rank through the fixed DDR2 mode-register, precharge and refresh ordering. Finally it issues a go step and waits for the memory controller to report readiness before raising `done`.

Commands leave on a single port as a valid/accept pair carrying chip select, bank address, a command code and an address/data word. The downstream controller turns each one into the real bus cycle. The sequencer advances only when a command is accepted. Pad delays are counted internally, and `cmd_valid` is low while they run.

Top module: `ddr2_init_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle in the next cycle, with `done` low and `cmd_valid` low.
- R2: `start` begins a sequence only from idle or from the done state. A `start` pulse while a sequence is in progress has no effect on the command stream.
- R3: While `cmd_valid` is high and `cmd_ready` is low, all command fields stay unchanged. The sequence moves on only in a cycle with both high.
- R4: With calibration enabled, the first command is a drive-default write (op 4, bank 0, chip 0, address `DRV_DEFAULT`, 0x198 by default). The block then idles until bit 8 of `cal_status` is high.
- R5: One pad delay precedes the first rank command and, when there are no ranks, the go step.
- R6: Op codes are NOP=0, precharge-all=1, auto-refresh=2, mode-register set=3, drive-default=4, go=5. Each rank receives, in order: NOP, precharge-all, pad, MRS bank 2, MRS bank 3, MRS bank 1, MRS bank 0 with DLL reset, precharge-all, two auto-refreshes, MRS bank 0 with DLL reset cleared, pad, MRS bank 1 with OCD default, pad, MRS bank 1 with OCD exit, pad.
- R7: The first three extended writes carry address 0. The DLL-reset write carries `cfg_mr` with bit 8 forced to 1, and the later bank-0 write carries it with bit 8 forced to 0. The two OCD writes carry `cfg_emr` with bits 9:7 forced to 111 and then to 000.
- R8: Each pad delay holds `cmd_valid` low for exactly 10*(`cfg_delay`+1) cycles.
- R9: Ranks are visited in ascending order 0 to N-1, and every rank command carries its index on `cmd_cs`. A count of 0 skips the rank loop. A count above `MAX_CHIPS` is treated as `MAX_CHIPS`.
- R10: After the last rank, a go command (op 5, bank 0, chip 0, address 0) is issued. The block then waits for `mem_ready`. `done` rises the cycle after `mem_ready` is seen high, and stays high until `start` or reset.
- R11: Configuration inputs are sampled only at an accepted start. Later changes to them do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (idle or done only) |
| cfg_chips | input | CS_W+1 | Number of ranks to initialize |
| cfg_mr | input | AW | Base mode-register value |
| cfg_emr | input | AW | Base extended-mode value |
| cfg_delay | input | DLY_W | Wait-unit length minus one |
| cfg_cal_en | input | 1 | Enable drive-default write and calibration wait |
| cal_status | input | CAL_W | Calibration status; bit 8 means complete |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted by downstream |
| cmd_cs | output | CS_W | Chip select index |
| cmd_bank | output | 2 | Bank address (mode-register selector) |
| cmd_op | output | 3 | Command code |
| cmd_addr | output | AW | Address/data word |
| mem_ready | input | 1 | Controller ready after go step |
| done | output | 1 | Initialization complete |

## Verification
The bench builds the block with its default parameters: four ranks maximum, a 14-bit address word and an 8-bit delay field. With these values, rank counts 0 through 4 and a clamped count of 7 can all be run in full. Pad lengths of one to three cycles per unit keep the complete command stream short enough that every command and every delay cycle can be compared cycle by cycle. Accept patterns of always, every other cycle and two in three stress the hold-until-accepted rule. Runs with calibration on and off, a stray start in mid-sequence, a mid-run reset, and configuration inputs scrambled after start cover the remaining behaviour.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PREA = 3'd1,
        OP_REF  = 3'd2,
        OP_MRS  = 3'd3,
        OP_DRV  = 3'd4,
        OP_GO   = 3'd5
    } op_e;

    typedef enum logic {
        K_CMD = 1'b0,
        K_DLY = 1'b1
    } kind_e;

    typedef enum logic [2:0] {
        AD_ZERO     = 3'd0,
        AD_MR_DLL   = 3'd1,
        AD_MR       = 3'd2,
        AD_OCD_DFLT = 3'd3,
        AD_OCD_EXIT = 3'd4
    } asel_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DRV  = 3'd1,
        ST_CAL  = 3'd2,
        ST_PAD  = 3'd3,
        ST_CHIP = 3'd4,
        ST_GO   = 3'd5,
        ST_RDY  = 3'd6,
        ST_DONE = 3'd7
    } state_e;

    typedef struct packed {
        kind_e       kind;
        op_e         op;
        logic [1:0]  bank;
        asel_e       asel;
    } step_t;

    localparam logic [3:0] LAST_STEP    = 4'd15;
    localparam int         PAD_UNITS    = 10;
    localparam int         DLL_RST_BIT  = 8;
    localparam int         OCD_LSB      = 7;
    localparam int         CAL_DONE_BIT = 8;

    // Per-rank micro-program: index -> what to emit
    function automatic step_t chip_step(input logic [3:0] idx);
        step_t s;
        s.kind = K_CMD;
        s.op   = OP_NOP;
        s.bank = 2'd0;
        s.asel = AD_ZERO;
        case (idx)
            4'd1, 4'd7:                 s.op = OP_PREA;
            4'd2, 4'd11, 4'd13, 4'd15:  s.kind = K_DLY;
            4'd3:  begin s.op = OP_MRS; s.bank = 2'd2; end
            4'd4:  begin s.op = OP_MRS; s.bank = 2'd3; end
            4'd5:  begin s.op = OP_MRS; s.bank = 2'd1; end
            4'd6:  begin s.op = OP_MRS; s.asel = AD_MR_DLL; end
            4'd8, 4'd9:                 s.op = OP_REF;
            4'd10: begin s.op = OP_MRS; s.asel = AD_MR; end
            4'd12: begin s.op = OP_MRS; s.bank = 2'd1; s.asel = AD_OCD_DFLT; end
            4'd14: begin s.op = OP_MRS; s.bank = 2'd1; s.asel = AD_OCD_EXIT; end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pad_timer.sv
module pad_timer #(
    parameter int DLY_W = 8,
    parameter int UNITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] len,
    output logic             expired
);
    localparam int RW = (UNITS > 1) ? $clog2(UNITS) : 1;
    localparam logic [RW-1:0] REP_INIT = RW'(UNITS - 1);

    logic [DLY_W-1:0] len_q;
    logic [DLY_W-1:0] unit_q;
    logic [RW-1:0]    rep_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            len_q  <= '0;
            unit_q <= '0;
            rep_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            len_q  <= len;
            unit_q <= len;
            rep_q  <= REP_INIT;
        end else if (busy_q) begin
            if (unit_q == '0) begin
                if (rep_q == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    rep_q  <= rep_q - RW'(1);
                    unit_q <= len_q;
                end
            end else begin
                unit_q <= unit_q - DLY_W'(1);
            end
        end
    end

    assign expired = busy_q && (unit_q == '0) && (rep_q == '0);
endmodule

// File: rtl/init_fsm.sv
module init_fsm
    import ddr2_init_pkg::*;
#(
    parameter int MAX_CHIPS = 4,
    parameter int CS_W      = 2,
    parameter int AW        = 14,
    parameter int DLY_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CS_W:0]    cfg_chips,
    input  logic [AW-1:0]    cfg_mr,
    input  logic [AW-1:0]    cfg_emr,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             cfg_cal_en,
    input  logic             cal_ok,
    input  logic             mem_ready,
    input  logic             cmd_fire,
    input  logic             dly_expired,
    output state_e           state,
    output logic [3:0]       step_idx,
    output logic [CS_W-1:0]  chip,
    output logic [AW-1:0]    mr_q,
    output logic [AW-1:0]    emr_q,
    output logic             dly_load,
    output logic [DLY_W-1:0] dly_len
);
    localparam logic [CS_W:0] MAX_C = MAX_CHIPS[CS_W:0];

    state_e           nxt_state;
    logic [3:0]       nxt_idx;
    logic [CS_W-1:0]  nxt_chip;
    logic [CS_W:0]    chips_q;
    logic [CS_W:0]    chips_in;
    logic [DLY_W-1:0] dly_q;
    logic             accept_start;
    logic             last_chip;
    step_t            cur;
    step_t            nxt_step;

    assign accept_start = start && (state == ST_IDLE || state == ST_DONE);
    assign chips_in     = (cfg_chips > MAX_C) ? MAX_C : cfg_chips;
    assign last_chip    = (({1'b0, chip} + (CS_W+1)'(1)) == chips_q);
    assign cur          = chip_step(step_idx);
    assign nxt_step     = chip_step(step_idx + 4'd1);
    assign dly_len      = accept_start ? cfg_delay : dly_q;

    always_comb begin
        nxt_state = state;
        nxt_idx   = step_idx;
        nxt_chip  = chip;
        dly_load  = 1'b0;
        case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    if (cfg_cal_en) begin
                        nxt_state = ST_DRV;
                    end else begin
                        nxt_state = ST_PAD;
                        dly_load  = 1'b1;
                    end
                end
            end
            ST_DRV: if (cmd_fire) nxt_state = ST_CAL;
            ST_CAL: begin
                if (cal_ok) begin
                    nxt_state = ST_PAD;
                    dly_load  = 1'b1;
                end
            end
            ST_PAD: begin
                if (dly_expired) begin
                    nxt_idx   = 4'd0;
                    nxt_chip  = '0;
                    nxt_state = (chips_q == '0) ? ST_GO : ST_CHIP;
                end
            end
            ST_CHIP: begin
                if ((cur.kind == K_CMD) ? cmd_fire : dly_expired) begin
                    if (step_idx == LAST_STEP) begin
                        nxt_idx = 4'd0;
                        if (last_chip) nxt_state = ST_GO;
                        else           nxt_chip  = chip + CS_W'(1);
                    end else begin
                        nxt_idx  = step_idx + 4'd1;
                        dly_load = (nxt_step.kind == K_DLY);
                    end
                end
            end
            ST_GO:  if (cmd_fire)  nxt_state = ST_RDY;
            ST_RDY: if (mem_ready) nxt_state = ST_DONE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_idx <= 4'd0;
            chip     <= '0;
        end else begin
            state    <= nxt_state;
            step_idx <= nxt_idx;
            chip     <= nxt_chip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chips_q <= '0;
            mr_q    <= '0;
            emr_q   <= '0;
            dly_q   <= '0;
        end else if (accept_start) begin
            chips_q <= chips_in;
            mr_q    <= cfg_mr;
            emr_q   <= cfg_emr;
            dly_q   <= cfg_delay;
        end
    end
endmodule

// File: rtl/cmd_encoder.sv
module cmd_encoder
    import ddr2_init_pkg::*;
#(
    parameter int            AW       = 14,
    parameter int            CS_W     = 2,
    parameter logic [AW-1:0] DRV_WORD = 'h198
) (
    input  state_e          state,
    input  step_t           step,
    input  logic [CS_W-1:0] chip,
    input  logic [AW-1:0]   mr,
    input  logic [AW-1:0]   emr,
    output logic            valid,
    output op_e             op,
    output logic [1:0]      bank,
    output logic [CS_W-1:0] cs,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] DLL_M = {{(AW-1){1'b0}}, 1'b1} << DLL_RST_BIT;
    localparam logic [AW-1:0] OCD_M = {{(AW-3){1'b0}}, 3'b111} << OCD_LSB;

    logic [AW-1:0] word;

    always_comb begin
        case (step.asel)
            AD_MR_DLL:   word = mr | DLL_M;
            AD_MR:       word = mr & ~DLL_M;
            AD_OCD_DFLT: word = emr | OCD_M;
            AD_OCD_EXIT: word = emr & ~OCD_M;
            default:     word = '0;
        endcase
    end

    always_comb begin
        valid = 1'b0;
        op    = OP_NOP;
        bank  = 2'd0;
        cs    = '0;
        addr  = '0;
        case (state)
            ST_DRV: begin
                valid = 1'b1;
                op    = OP_DRV;
                addr  = DRV_WORD;
            end
            ST_GO: begin
                valid = 1'b1;
                op    = OP_GO;
            end
            ST_CHIP: begin
                if (step.kind == K_CMD) begin
                    valid = 1'b1;
                    op    = step.op;
                    bank  = step.bank;
                    cs    = chip;
                    addr  = word;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int            MAX_CHIPS   = 4,
    parameter int            AW          = 14,
    parameter int            DLY_W       = 8,
    parameter int            CAL_W       = 16,
    parameter logic [AW-1:0] DRV_DEFAULT = 'h198,
    parameter int            CS_W        = (MAX_CHIPS > 1) ? $clog2(MAX_CHIPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CS_W:0]    cfg_chips,
    input  logic [AW-1:0]    cfg_mr,
    input  logic [AW-1:0]    cfg_emr,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             cfg_cal_en,
    input  logic [CAL_W-1:0] cal_status,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CS_W-1:0]  cmd_cs,
    output logic [1:0]       cmd_bank,
    output logic [2:0]       cmd_op,
    output logic [AW-1:0]    cmd_addr,
    input  logic             mem_ready,
    output logic             done
);
    state_e           state;
    logic [3:0]       step_idx;
    logic [CS_W-1:0]  chip;
    logic [AW-1:0]    mr_q;
    logic [AW-1:0]    emr_q;
    logic             dly_load;
    logic [DLY_W-1:0] dly_len;
    logic             dly_expired;
    logic             cmd_fire;
    step_t            cur_step;
    op_e              op_enc;

    assign cur_step = chip_step(step_idx);
    assign cmd_fire = cmd_valid && cmd_ready;
    assign cmd_op   = op_enc;
    assign done     = (state == ST_DONE);

    init_fsm #(
        .MAX_CHIPS (MAX_CHIPS),
        .CS_W      (CS_W),
        .AW        (AW),
        .DLY_W     (DLY_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_chips   (cfg_chips),
        .cfg_mr      (cfg_mr),
        .cfg_emr     (cfg_emr),
        .cfg_delay   (cfg_delay),
        .cfg_cal_en  (cfg_cal_en),
        .cal_ok      (cal_status[CAL_DONE_BIT]),
        .mem_ready   (mem_ready),
        .cmd_fire    (cmd_fire),
        .dly_expired (dly_expired),
        .state       (state),
        .step_idx    (step_idx),
        .chip        (chip),
        .mr_q        (mr_q),
        .emr_q       (emr_q),
        .dly_load    (dly_load),
        .dly_len     (dly_len)
    );

    pad_timer #(
        .DLY_W (DLY_W),
        .UNITS (PAD_UNITS)
    ) u_pad (
        .clk     (clk),
        .rst     (rst),
        .load    (dly_load),
        .len     (dly_len),
        .expired (dly_expired)
    );

    cmd_encoder #(
        .AW       (AW),
        .CS_W     (CS_W),
        .DRV_WORD (DRV_DEFAULT)
    ) u_enc (
        .state (state),
        .step  (cur_step),
        .chip  (chip),
        .mr    (mr_q),
        .emr   (emr_q),
        .valid (cmd_valid),
        .op    (op_enc),
        .bank  (cmd_bank),
        .cs    (cmd_cs),
        .addr  (cmd_addr)
    );
endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk #(
    parameter int AW   = 14,
    parameter int CS_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [CS_W-1:0] cmd_cs,
    input logic [1:0]      cmd_bank,
    input logic [2:0]      cmd_op,
    input logic [AW-1:0]   cmd_addr,
    input logic            mem_ready,
    input logic            done
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!done && !cmd_valid));

    // R3
    hold_until_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                       && $stable(cmd_cs) && $stable(cmd_addr)));

    // R6
    legal_op_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op <= 3'd5));

    // R10
    done_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_ready));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R2
    done_leaves_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> ($past(start) || $past(rst)));
endmodule

bind ddr2_init_seq ddr2_init_chk #(
    .AW   (AW),
    .CS_W (CS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_cs    (cmd_cs),
    .cmd_bank  (cmd_bank),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .mem_ready (mem_ready),
    .done      (done)
);

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;
    localparam int AW = 14;
    localparam int CS_W = 2;
    localparam int DRV = 'h198;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CS_W:0]   cfg_chips = '0;
    logic [AW-1:0]   cfg_mr = '0;
    logic [AW-1:0]   cfg_emr = '0;
    logic [7:0]      cfg_delay = '0;
    logic            cfg_cal_en = 1'b0;
    logic [15:0]     cal_status = '0;
    logic            cmd_valid;
    logic            cmd_ready = 1'b0;
    logic [CS_W-1:0] cmd_cs;
    logic [1:0]      cmd_bank;
    logic [2:0]      cmd_op;
    logic [AW-1:0]   cmd_addr;
    logic            mem_ready = 1'b0;
    logic            done;

    always #2.5 clk = ~clk;

    ddr2_init_seq dut (
        .clk(clk), .rst(rst), .start(start), .cfg_chips(cfg_chips),
        .cfg_mr(cfg_mr), .cfg_emr(cfg_emr), .cfg_delay(cfg_delay),
        .cfg_cal_en(cfg_cal_en), .cal_status(cal_status),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cs(cmd_cs),
        .cmd_bank(cmd_bank), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .mem_ready(mem_ready), .done(done)
    );

    localparam int IT_CMD = 0, IT_PAD = 1, IT_WCAL = 2, IT_WRDY = 3, IT_DONE = 4;
    typedef struct {
        int    kind;
        int    op;
        int    bank;
        int    cs;
        int    addr;
        int    n;
        string tag;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    task automatic push(input int kind, input int op, input int bank, input int cs,
                        input int addr, input int n, input string tag);
        exp_t e;
        e.kind = kind; e.op = op; e.bank = bank; e.cs = cs;
        e.addr = addr & 'h3fff; e.n = n; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic build(input int chips, input int mr, input int emr,
                         input int dly, input bit cal);
        int n;
        int pad;
        n = (chips > 4) ? 4 : chips;          // R9 clamp
        pad = 10 * (dly + 1);                 // R8 pad length
        q.delete();
        if (cal) begin
            push(IT_CMD, 4, 0, 0, DRV, 0, "R4");
            push(IT_WCAL, 0, 0, 0, 0, 0, "R4");
        end
        push(IT_PAD, 0, 0, 0, 0, pad, "R5");
        for (int c = 0; c < n; c++) begin
            push(IT_CMD, 0, 0, c, 0, 0, "R6");
            push(IT_CMD, 1, 0, c, 0, 0, "R6");
            push(IT_PAD, 0, 0, 0, 0, pad, "R8");
            push(IT_CMD, 3, 2, c, 0, 0, "R7");
            push(IT_CMD, 3, 3, c, 0, 0, "R7");
            push(IT_CMD, 3, 1, c, 0, 0, "R7");
            push(IT_CMD, 3, 0, c, mr | 'h100, 0, "R7");
            push(IT_CMD, 1, 0, c, 0, 0, "R6");
            push(IT_CMD, 2, 0, c, 0, 0, "R6");
            push(IT_CMD, 2, 0, c, 0, 0, "R6");
            push(IT_CMD, 3, 0, c, mr & ~'h100, 0, "R7");
            push(IT_PAD, 0, 0, 0, 0, pad, "R8");
            push(IT_CMD, 3, 1, c, emr | 'h380, 0, "R7");
            push(IT_PAD, 0, 0, 0, 0, pad, "R8");
            push(IT_CMD, 3, 1, c, emr & ~'h380, 0, "R7");
            push(IT_PAD, 0, 0, 0, 0, pad, "R9");
        end
        push(IT_CMD, 5, 0, 0, 0, 0, "R10");
        push(IT_WRDY, 0, 0, 0, 0, 0, "R10");
        push(IT_DONE, 0, 0, 0, 0, 0, "R10");
    endtask

    // Runs one full sequence; compares every cycle against the queue.
    task automatic run(input int chips, input int mr, input int emr, input int dly,
                       input bit cal, input int mode, input int busy_at);
        int cyc;
        int wcnt;
        bit fin;
        cyc = 0; wcnt = 0; fin = 0;
        build(chips, mr, emr, dly, cal);
        @(negedge clk);
        cfg_chips = 3'(chips); cfg_mr = 14'(mr); cfg_emr = 14'(emr);
        cfg_delay = 8'(dly); cfg_cal_en = cal; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: scramble configuration after start
        cfg_chips = 3'd1; cfg_mr = ~14'(mr); cfg_emr = ~14'(emr);
        cfg_delay = 8'(dly + 3); cfg_cal_en = ~cal;
        while (!fin) begin
            case (mode)
                1:       cmd_ready = (cyc % 2) == 1;
                2:       cmd_ready = (cyc % 3) != 0;
                default: cmd_ready = 1'b1;
            endcase
            start = (cyc == busy_at);                 // R2 stray start
            cal_status = (q[0].kind == IT_WCAL && wcnt >= 3) ? 16'h01FF : 16'h00FF;
            mem_ready  = (q[0].kind == IT_WRDY && wcnt >= 2);
            #1;
            case (q[0].kind)
                IT_CMD: begin
                    check(cmd_valid == 1'b1, q[0].tag, "valid", int'(cmd_valid), 1);
                    check(int'(cmd_op) == q[0].op, q[0].tag, "op", int'(cmd_op), q[0].op);
                    check(int'(cmd_bank) == q[0].bank, q[0].tag, "bank", int'(cmd_bank), q[0].bank);
                    check(int'(cmd_cs) == q[0].cs, "R9", "cs", int'(cmd_cs), q[0].cs);
                    check(int'(cmd_addr) == q[0].addr, q[0].tag, "addr", int'(cmd_addr), q[0].addr);
                    if (cmd_ready) begin void'(q.pop_front()); wcnt = 0; end
                    else if (cyc % 5 == 0)
                        check(cmd_valid == 1'b1, "R3", "held valid", int'(cmd_valid), 1);
                end
                IT_PAD: begin
                    check(cmd_valid == 1'b0 && done == 1'b0, q[0].tag, "pad idle",
                          int'(cmd_valid), 0);
                    q[0].n = q[0].n - 1;
                    if (q[0].n == 0) begin void'(q.pop_front()); wcnt = 0; end
                end
                IT_WCAL: begin
                    check(cmd_valid == 1'b0, "R4", "cal wait valid", int'(cmd_valid), 0);
                    wcnt++;
                    if (cal_status[8]) begin void'(q.pop_front()); wcnt = 0; end
                end
                IT_WRDY: begin
                    check(cmd_valid == 1'b0 && done == 1'b0, "R10", "ready wait",
                          int'(done), 0);
                    wcnt++;
                    if (mem_ready) begin void'(q.pop_front()); wcnt = 0; end
                end
                default: begin
                    check(done == 1'b1 && cmd_valid == 1'b0, "R10", "done", int'(done), 1);
                    void'(q.pop_front());
                    fin = 1;
                end
            endcase
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; mem_ready = 1'b0; cmd_ready = 1'b0;
        repeat (2) begin
            #1;
            check(done == 1'b1, "R10", "done held", int'(done), 1);
            @(negedge clk);
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(done == 1'b0, "R1", "reset done", int'(done), 0);
        check(cmd_valid == 1'b0, "R1", "reset valid", int'(cmd_valid), 0);
        @(negedge clk);
        rst = 1'b0;

        run(1, 'h0432, 'h0044, 0, 1'b0, 0, -1);
        run(2, 'h0a52, 'h0006, 2, 1'b1, 1, 30);
        run(3, 'h0132, 'h0284, 1, 1'b0, 2, 70);
        run(4, 'h3fff, 'h3c7f, 0, 1'b1, 1, -1);
        run(0, 'h0242, 'h0000, 1, 1'b0, 0, 5);
        run(7, 'h0042, 'h0380, 0, 1'b0, 2, -1);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        cfg_chips = 3'd2; cfg_delay = 8'd0; cfg_cal_en = 1'b0; cmd_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (25) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(cmd_valid == 1'b0, "R1", "mid reset valid", int'(cmd_valid), 0);
        check(done == 1'b0, "R1", "mid reset done", int'(done), 0);
        rst = 1'b0;
        repeat (20) begin
            @(negedge clk);
            #1;
            check(cmd_valid == 1'b0, "R1", "idle after reset", int'(cmd_valid), 0);
        end

        run(2, 'h0652, 'h0040, 0, 1'b0, 0, -1);

        summary();
        $finish;
    end
endmodule